// File: doc/BRIEF.md
# Flash End-of-Write Polling Controller

This controller sits on the host side of a parallel flash device. It decides when an internal program or erase has finished by reading one status location over and over. A start pulse launches a poll. With the pulse come the operation kind (program or erase), the check method, the address to poll and, for a program, the data that was written. The controller then issues reads over a simple request/acknowledge read port and judges each returned word.

The check method is one of two. The first compares bit 7 against a target: the written data's bit 7 for a program, or a 1 for an erase. The second watches bit 6 and expects it to stop changing between consecutive reads. A read can land at the same moment the internal write ends, so a single good read is not trusted. Two more reads that are also good must follow before completion is accepted. After that the controller waits a settling interval so that the remaining data lines become valid. It then makes one last read and presents that word with a done pulse. If no confirmed completion arrives within a bounded number of polling cycles, the controller raises a timeout pulse and returns to idle.

Top module: `flash_eow_poller`

## Requirements
- R1: After reset, `busy_o`, `rd_req_o`, `done_o` and `timeout_o` are 0 and `final_data_o` is all zeros.
- R2: A start pulse in idle latches the operation, method, address and expected data, and raises `busy_o` and `rd_req_o` on the next cycle. `rd_addr_o` then equals the latched address, and no read is requested while idle.
- R3: A start pulse while a poll is in progress is ignored: the poll in progress keeps its latched settings and its timing.
- R4: Bit-7 method with a program (`method_i`=0, `op_erase_i`=0): a read is good when data bit 7 equals bit 7 of `exp_data_i`.
- R5: Bit-7 method with an erase (`method_i`=0, `op_erase_i`=1): a read is good when data bit 7 is 1.
- R6: Toggle method (`method_i`=1): a read is good when its bit 6 equals bit 6 of the preceding poll read. The first read of a poll is never good.
- R7: Completion needs three good poll reads in a row. Any read that is not good restarts the count, and polling continues.
- R8: After completion is confirmed, `rd_req_o` stays low for exactly `SETTLE_CYC` cycles. The final read is then requested.
- R9: When the final read is acknowledged, its data appears on `final_data_o` and `done_o` pulses for one cycle as `busy_o` falls.
- R10: If the poll has not been confirmed when the polling phase reaches `TIMEOUT_CYC` cycles, `timeout_o` pulses for one cycle, `busy_o` falls, `rd_req_o` is withdrawn and no done is given.
- R11: Once raised, `rd_req_o` stays high until a cycle with `rd_ack_i` high, except when a timeout withdraws it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse for a new poll |
| op_erase_i | input | 1 | 1 = erase, 0 = program |
| method_i | input | 1 | 0 = bit-7 compare, 1 = bit-6 toggle |
| addr_i | input | AW | Location to poll |
| exp_data_i | input | DW | Data that was programmed |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_addr_o | output | AW | Read address |
| rd_ack_i | input | 1 | Read acknowledge, data valid in the same cycle |
| rd_data_i | input | DW | Read data |
| busy_o | output | 1 | Poll in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | One-cycle timeout pulse |
| final_data_o | output | DW | Data from the read after settling |

## Verification
The bench feeds reads in which one good read is followed by a bad one. A controller that trusts a single good read, or fails to restart its count, then finishes early. An erase and a program use opposite bit-7 targets, which exposes an inverted comparison. A toggle sequence keeps bit 6 stable only after it has alternated, which catches a controller that compares against the wrong read or counts the first read as good. A second start during a poll, a poll that never completes and the length of the settling gap are checked cycle by cycle. A design that restarts, never gives up, or reads too soon would show a mismatch on the request line.

// File: rtl/flash_eow_pkg.sv
package flash_eow_pkg;

  localparam int unsigned COMP_BIT  = 7;  // data-complement status bit
  localparam int unsigned TOGL_BIT  = 6;  // toggle status bit
  localparam int unsigned EXTRA_RDS = 2;  // confirming reads after first good one

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_REQ    = 3'd1,
    ST_EVAL   = 3'd2,
    ST_SETTLE = 3'd3,
    ST_FREQ   = 3'd4
  } poll_state_e;

  typedef enum logic {
    MTH_COMPARE = 1'b0,
    MTH_TOGGLE  = 1'b1
  } poll_method_e;

endpackage

// File: rtl/eow_cycle_timer.sv
module eow_cycle_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic en,
  output logic at_last
);
  localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);

  logic [CW-1:0] cnt_q;

  assign at_last = (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (en && !at_last) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/eow_status_judge.sv
module eow_status_judge
  import flash_eow_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          method_tgl,
  input  logic          op_erase,
  input  logic          exp_b7,
  input  logic [DW-1:0] rdata,
  input  logic          prev_b6,
  input  logic          have_prev,
  output logic          good
);
  logic cmp_good;
  logic tgl_good;

  always_comb begin
    if (op_erase) cmp_good = rdata[COMP_BIT];
    else          cmp_good = (rdata[COMP_BIT] == exp_b7);
    tgl_good = have_prev && (rdata[TOGL_BIT] == prev_b6);
    good     = method_tgl ? tgl_good : cmp_good;
  end
endmodule

// File: rtl/flash_eow_poller.sv
module flash_eow_poller
  import flash_eow_pkg::*;
#(
  parameter int unsigned DW          = 16,
  parameter int unsigned AW          = 20,
  parameter int unsigned SETTLE_CYC  = 64,
  parameter int unsigned TIMEOUT_CYC = 200000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          op_erase_i,
  input  logic          method_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] exp_data_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_ack_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          timeout_o,
  output logic [DW-1:0] final_data_o
);
  localparam int unsigned CFW = $clog2(EXTRA_RDS + 1);

  poll_state_e    state_q;
  logic           erase_q;
  logic           tgl_q;
  logic           exp7_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  rdata_q;
  logic           prev6_q;
  logic           have_q;
  logic [CFW-1:0] conf_q;
  logic           done_q;
  logic           tmo_q;
  logic [DW-1:0]  final_q;

  logic polling;
  logic tmo_last;
  logic set_last;
  logic good;

  assign polling = (state_q == ST_REQ) || (state_q == ST_EVAL);

  eow_cycle_timer #(.LIMIT(TIMEOUT_CYC)) u_tmo_tmr (
    .clk    (clk),
    .rst    (rst),
    .clear  (state_q == ST_IDLE),
    .en     (polling),
    .at_last(tmo_last)
  );

  eow_cycle_timer #(.LIMIT(SETTLE_CYC)) u_set_tmr (
    .clk    (clk),
    .rst    (rst),
    .clear  (state_q != ST_SETTLE),
    .en     (state_q == ST_SETTLE),
    .at_last(set_last)
  );

  eow_status_judge #(.DW(DW)) u_judge (
    .method_tgl(tgl_q),
    .op_erase  (erase_q),
    .exp_b7    (exp7_q),
    .rdata     (rdata_q),
    .prev_b6   (prev6_q),
    .have_prev (have_q),
    .good      (good)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      erase_q <= 1'b0;
      tgl_q   <= 1'b0;
      exp7_q  <= 1'b0;
      addr_q  <= '0;
      rdata_q <= '0;
      prev6_q <= 1'b0;
      have_q  <= 1'b0;
      conf_q  <= '0;
      done_q  <= 1'b0;
      tmo_q   <= 1'b0;
      final_q <= '0;
    end else begin
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            erase_q <= op_erase_i;
            tgl_q   <= method_i;
            exp7_q  <= exp_data_i[COMP_BIT];
            addr_q  <= addr_i;
            have_q  <= 1'b0;
            conf_q  <= '0;
            state_q <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (tmo_last) begin
            tmo_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else if (rd_ack_i) begin
            rdata_q <= rd_data_i;
            state_q <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          if (tmo_last) begin
            tmo_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            prev6_q <= rdata_q[TOGL_BIT];
            have_q  <= 1'b1;
            if (good && (conf_q == CFW'(EXTRA_RDS))) begin
              state_q <= ST_SETTLE;
            end else begin
              conf_q  <= good ? conf_q + 1'b1 : '0;
              state_q <= ST_REQ;
            end
          end
        end
        ST_SETTLE: begin
          if (set_last) state_q <= ST_FREQ;
        end
        ST_FREQ: begin
          if (rd_ack_i) begin
            final_q <= rd_data_i;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_req_o     = (state_q == ST_REQ) || (state_q == ST_FREQ);
  assign rd_addr_o    = addr_q;
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
  assign timeout_o    = tmo_q;
  assign final_data_o = final_q;
endmodule

// File: rtl/eow_poller_chk.sv
module eow_poller_chk (
  input logic clk,
  input logic rst,
  input logic rd_req_o,
  input logic rd_ack_i,
  input logic busy_o,
  input logic done_o,
  input logic timeout_o
);
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !rd_req_o);                                        // R2
  AST_START_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> rd_req_o);                                   // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);                                           // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);                                           // R9
  AST_DONE_TMO_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(done_o && timeout_o));                                       // R10
  AST_TMO_IDLE: assert property (@(posedge clk) disable iff (rst)
    timeout_o |-> !busy_o);                                        // R10
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    rd_req_o && !rd_ack_i |=> rd_req_o || timeout_o);              // R11
endmodule

bind flash_eow_poller eow_poller_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .rd_req_o (rd_req_o),
  .rd_ack_i (rd_ack_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .timeout_o(timeout_o)
);

// File: tb/flash_eow_poller_tb_top.sv
module flash_eow_poller_tb_top;
  localparam int DW = 16;
  localparam int AW = 8;
  localparam int SET = 5;
  localparam int TO  = 80;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, op_erase_i = 1'b0, method_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] exp_data_i = '0;
  logic rd_ack_i = 1'b0;
  logic [DW-1:0] rd_data_i = '0;
  logic rd_req_o, busy_o, done_o, timeout_o;
  logic [AW-1:0] rd_addr_o;
  logic [DW-1:0] final_data_o;

  int tests = 0, fails = 0;
  int done_cnt = 0, tmo_cnt = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  flash_eow_poller #(.DW(DW), .AW(AW), .SETTLE_CYC(SET), .TIMEOUT_CYC(TO)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .op_erase_i(op_erase_i),
    .method_i(method_i), .addr_i(addr_i), .exp_data_i(exp_data_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i),
    .rd_data_i(rd_data_i), .busy_o(busy_o), .done_o(done_o),
    .timeout_o(timeout_o), .final_data_o(final_data_o));

  // flash responder: words served in order, ack after two waiting cycles
  logic [DW-1:0] rsp_q[$];
  logic [DW-1:0] last_w = '0;
  int wcnt = 0;
  always @(negedge clk) begin
    if (rd_ack_i) begin
      rd_ack_i <= 1'b0;
      wcnt = 0;
    end else if (rd_req_o) begin
      wcnt++;
      if (wcnt >= 2) begin
        if (rsp_q.size() > 0) last_w = rsp_q.pop_front();
        rd_data_i <= last_w;
        rd_ack_i  <= 1'b1;
      end
    end
  end

  // behavioural reference: reads list judged against the requirement rules
  int ph = 0, tmr = 0, stl = 0, streak = 0;
  bit m_erase, m_tgl, m_e7, have;
  logic m_prev6;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] cur = '0, e_final = '0;
  bit e_done = 0, e_to = 0;
  bit ok;
  always @(posedge clk) begin
    if (rst) begin
      ph = 0; e_done = 0; e_to = 0; e_final = '0; m_addr = '0;
    end else begin
      e_done = 0; e_to = 0;
      if (ph == 0) begin
        if (start_i) begin
          m_erase = op_erase_i; m_tgl = method_i; m_e7 = exp_data_i[7];
          m_addr = addr_i; ph = 1; tmr = 0; streak = 0; have = 0;
        end
      end else if (ph == 1 || ph == 2) begin
        if (tmr == TO - 1) begin
          e_to = 1; ph = 0;
        end else begin
          tmr++;
          if (ph == 1) begin
            if (rd_ack_i) begin cur = rd_data_i; ph = 2; end
          end else begin
            if (m_tgl) ok = have && (cur[6] == m_prev6);          // R6
            else if (m_erase) ok = cur[7];                          // R5
            else ok = (cur[7] == m_e7);                             // R4
            m_prev6 = cur[6]; have = 1;
            streak = ok ? streak + 1 : 0;                           // R7
            if (streak == 3) begin ph = 3; stl = 0; end else ph = 1;
          end
        end
      end else if (ph == 3) begin
        if (stl == SET - 1) ph = 4; else stl++;                    // R8
      end else begin
        if (rd_ack_i) begin e_final = rd_data_i; e_done = 1; ph = 0; end
      end
    end
  end

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    tests++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk(busy_o == (ph != 0), "R3 busy_o", busy_o, ph != 0);
      chk(rd_req_o == (ph == 1 || ph == 4), "R8/R11 rd_req_o", rd_req_o, ph == 1 || ph == 4);
      chk(done_o == e_done, "R9 done_o", done_o, e_done);
      chk(timeout_o == e_to, "R10 timeout_o", timeout_o, e_to);
      chk(final_data_o == e_final, "R9 final_data_o", final_data_o, e_final);
      if (busy_o) chk(rd_addr_o == m_addr, "R2 rd_addr_o", rd_addr_o, m_addr);
      if (done_o) done_cnt++;
      if (timeout_o) tmo_cnt++;
    end
  end

  task automatic launch(input bit er, input bit mt, input logic [AW-1:0] a,
                        input logic [DW-1:0] ex);
    @(negedge clk);
    start_i = 1; op_erase_i = er; method_i = mt; addr_i = a; exp_data_i = ex;
    @(negedge clk);
    start_i = 0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 400 && !(done_o || timeout_o); i++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy_o == 0 && rd_req_o == 0 && done_o == 0 && timeout_o == 0, "R1 outputs", busy_o, 0);
    chk(final_data_o == '0, "R1 final_data_o", final_data_o, 0);
    rst = 0;

    // R4: program, bit 7 target is 1
    rsp_q = '{16'h0025, 16'h0000, 16'h00A5, 16'h00A5, 16'h00A5, 16'h12A5};
    launch(0, 0, 8'h31, 16'h00A5);
    chk(busy_o && rd_req_o, "R2 request after start", rd_req_o, 1);
    wait_end();
    chk(done_cnt == 1 && final_data_o == 16'h12A5, "R4 program done", final_data_o, 16'h12A5);

    // R7: good, bad, good, good, bad, then three good
    rsp_q = '{16'h0080, 16'h0000, 16'h0080, 16'h0080, 16'h0001, 16'h0080,
              16'h0080, 16'h0080, 16'h5A80};
    launch(0, 0, 8'h44, 16'h0080);
    wait_end();
    chk(done_cnt == 2 && final_data_o == 16'h5A80, "R7 restart on bad read", final_data_o, 16'h5A80);

    // R5: erase, bit 7 must read 1 regardless of exp
    rsp_q = '{16'h007F, 16'h0000, 16'h0080, 16'h0080, 16'h0080, 16'hFFFF};
    launch(1, 0, 8'h07, 16'h0000);
    wait_end();
    chk(done_cnt == 3 && final_data_o == 16'hFFFF, "R5 erase done", final_data_o, 16'hFFFF);

    // R6: toggle, bit 6 alternates then holds
    rsp_q = '{16'h0040, 16'h0000, 16'h0040, 16'h0000, 16'h0000, 16'h0000,
              16'h0000, 16'h3C3C};
    launch(0, 1, 8'h99, 16'h0000);
    wait_end();
    chk(done_cnt == 4 && final_data_o == 16'h3C3C, "R6 toggle done", final_data_o, 16'h3C3C);

    // R3: second start mid-poll with a different target is ignored
    rsp_q = '{16'h0000, 16'h0000, 16'h0080, 16'h0080, 16'h0080, 16'h7788};
    launch(0, 0, 8'h12, 16'h0080);
    repeat (4) @(negedge clk);
    start_i = 1; exp_data_i = 16'h0000; addr_i = 8'hEE;
    @(negedge clk);
    start_i = 0;
    wait_end();
    chk(done_cnt == 5 && final_data_o == 16'h7788, "R3 restart ignored", final_data_o, 16'h7788);

    // R10: never completes
    rsp_q = '{16'h0000};
    launch(0, 0, 8'h55, 16'h0080);
    wait_end();
    chk(tmo_cnt == 1 && done_cnt == 5, "R10 timeout", tmo_cnt, 1);
    chk(!busy_o && !rd_req_o, "R10 idle after timeout", busy_o, 0);

    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule